// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Output Timing

This block is a 36-bit first-in first-out buffer that carries words from a write port to a read port. Each port has its own free-running clock. The two clocks may be unrelated or the same. The depth is a parameter; 256 and 1024 words are the intended settings. Each side sees only its own flags. The write side has an input-side ready flag and an almost-full flag, both computed against a read pointer brought over through two flops on the write clock. The read side has an output-side ready flag and an almost-empty flag, both computed against a write pointer brought over through two flops on the read clock. A configuration block outside this one supplies the almost-empty and almost-full thresholds.

A full reset samples `fwftSel` and so picks the output timing for the whole session:

- **Standard timing.** A stored word reaches `rdData` only in response to a read. `readyRd` means "not empty" and `readyWr` means "not full".
- **Fall-through timing.** The oldest word is presented on `rdData` with no read request. `readyRd` then means "the output holds a valid word" and `readyWr` means "memory has space".

A partial reset empties the buffer and keeps the selected timing.

Top module: `dcFifo`

## Requirements
- R1: Every word accepted at the write port leaves the read port once, unaltered and in write order. This holds when writes and reads run at the same time on unrelated clocks.
- R2: In standard timing, a read is accepted when `rdEn` is high and `readyRd` is high at a read-clock edge; that edge loads the next word into `rdData`. `rdData` changes at no other time, so a written word is never shown without a read. After either reset, `rdData` reads zero.
- R3: In fall-through timing, the oldest word appears on `rdData` with `readyRd` high and no `rdEn`. A read-clock edge with `rdEn` and `readyRd` both high replaces it with the next word, or drops `readyRd` if no word remains.
- R4: `readyWr` is low exactly when the memory array holds DEPTH words. In standard timing, `readyRd` is high exactly when the memory array holds at least one word.
- R5: A write while `readyWr` is low and a read while `readyRd` is low are ignored. Later traffic is still stored and returned correctly.
- R6: `almostEmpty` is high when the number of words held is less than or equal to `aeOffset`. In fall-through timing, the word in the output register counts as held.
- R7: `almostFull` is high when DEPTH minus the number of words in the memory array is less than or equal to `afOffset`.
- R8: In fall-through timing, the output register adds one storage place, so DEPTH+1 words can be held. `readyRd` falls only after a read that takes the last word.
- R9: A partial reset (`prstN` low) empties the buffer and keeps the timing selected earlier, whatever `fwftSel` is. A full reset (`rstN` low) empties the buffer and loads the timing from `fwftSel`, where 0 selects standard and 1 selects fall-through.
- R10: Pointers cross between the clocks in Gray code. Each exported pointer changes in at most one bit per clock of its own domain. A change on one side reaches the other side's flags within a few cycles of the other side's clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Full reset, active low; flushes the buffer and samples `fwftSel` |
| prstN | input | 1 | Partial reset, active low; flushes the buffer only |
| fwftSel | input | 1 | Timing choice read during full reset: 0 selects standard, 1 selects fall-through |
| aeOffset | input | log2(DEPTH)+1 | Almost-empty threshold |
| afOffset | input | log2(DEPTH)+1 | Almost-full threshold |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Write word |
| readyWr | output | 1 | Memory has space (not full) |
| almostFull | output | 1 | Free space is at or below `afOffset` |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Output register |
| readyRd | output | 1 | Standard timing: not empty; fall-through timing: output word valid |
| almostEmpty | output | 1 | Held words are at or below `aeOffset` |

## Verification
The buffer is exercised with five kinds of traffic:

- **Single words into an empty buffer.** Shows whether a word reaches the output with no read (fall-through) or waits for one (standard).
- **Random concurrent traffic on clocks of different periods.** Separates correct Gray crossing and ordering from lost, duplicated or reordered words.
- **Burst fills and burst drains with requests held high past full and past empty.** Show that requests made while not ready leave the pointers intact. The fall-through fill shows the extra storage place in the output register.
- **Single-word steps across each threshold.** Distinguish "at or below" from "below" for both almost flags.
- **Partial and full resets with the opposite `fwftSel` value applied.** Show which reset loads the timing choice and which keeps it.

// File: rtl/dcFifoPkg.sv
`timescale 1ns/1ps
package dcFifoPkg;

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic wrPush;   // write-clock domain: store wrData at wrAddr
    logic rdLoad;   // read-clock domain: load output register from rdAddr
    logic rdClear;  // read-clock domain: clear output register
  } fifoStrobes_t;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } timingMode_t;

endpackage

// File: rtl/dcFifoPtrSync.sv
`timescale 1ns/1ps
module dcFifoPtrSync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  // Two-flop capture of a Gray-coded pointer from the other domain.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= grayIn;
      stage2 <= stage1;
    end
  end

  // Gray to binary: each bit is the parity of the Gray bits at and above it.
  always_comb begin
    for (int i = 0; i < W; i++) begin
      binOut[i] = ^(stage2 >> i);
    end
  end

endmodule

// File: rtl/dcFifoCtrl.sv
`timescale 1ns/1ps
module dcFifoCtrl
  import dcFifoPkg::*;
#(
  parameter  int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              prstN,
  input  logic              fwftSel,
  input  logic [PTR_W-1:0]  aeOffset,
  input  logic [PTR_W-1:0]  afOffset,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output fifoStrobes_t      strobes,
  output logic              readyWr,
  output logic              almostFull,
  output logic              readyRd,
  output logic              almostEmpty
);

  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  // ---------------------------------------------------------------- resets
  logic       anyRstN;
  logic [1:0] wrRstPipe;
  logic [1:0] rdRstPipe;
  logic [1:0] rdCfgPipe;
  logic       wrLive;
  logic       rdLive;

  assign anyRstN = rstN & prstN;

  always_ff @(posedge wrClk or negedge anyRstN) begin
    if (!anyRstN) wrRstPipe <= '0;
    else          wrRstPipe <= {wrRstPipe[0], 1'b1};
  end

  always_ff @(posedge rdClk or negedge anyRstN) begin
    if (!anyRstN) rdRstPipe <= '0;
    else          rdRstPipe <= {rdRstPipe[0], 1'b1};
  end

  // Full reset only: drives the capture of the timing choice.
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rdCfgPipe <= '0;
    else       rdCfgPipe <= {rdCfgPipe[0], 1'b1};
  end

  assign wrLive = wrRstPipe[1];
  assign rdLive = rdRstPipe[1];

  timingMode_t mode;

  always_ff @(posedge rdClk) begin
    if (!rdCfgPipe[1]) mode <= timingMode_t'(fwftSel);
  end

  // ------------------------------------------------------------ write side
  logic [PTR_W-1:0] wrBin;
  logic [PTR_W-1:0] wrGray;
  logic [PTR_W-1:0] wrBinNext;
  logic [PTR_W-1:0] rdSyncBin;
  logic [PTR_W-1:0] wrCount;
  logic             wrFull;
  logic             wrPush;
  logic [PTR_W-1:0] rdGray;

  assign wrBinNext = wrBin + PTR_W'(1);
  assign wrCount   = wrBin - rdSyncBin;
  assign wrFull    = (wrCount == DEPTH_P);
  assign wrPush    = wrEn & ~wrFull;

  always_ff @(posedge wrClk or negedge wrLive) begin
    if (!wrLive) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrPush) begin
      wrBin  <= wrBinNext;
      wrGray <= wrBinNext ^ (wrBinNext >> 1);
    end
  end

  dcFifoPtrSync #(.W(PTR_W)) u_rdToWr (
    .clk   (wrClk),
    .rstN  (wrLive),
    .grayIn(rdGray),
    .binOut(rdSyncBin)
  );

  assign readyWr    = ~wrFull;
  assign almostFull = (DEPTH_P - wrCount) <= afOffset;
  assign wrAddr     = wrBin[ADDR_W-1:0];

  // ------------------------------------------------------------- read side
  logic [PTR_W-1:0] rdBin;
  logic [PTR_W-1:0] rdBinNext;
  logic [PTR_W-1:0] wrSyncBin;
  logic [PTR_W-1:0] memCount;
  logic [PTR_W:0]   rdOcc;
  logic             memEmpty;
  logic             outValid;
  logic             rdLoad;

  assign rdBinNext = rdBin + PTR_W'(1);
  assign memCount  = wrSyncBin - rdBin;
  assign memEmpty  = (memCount == '0);

  always_comb begin
    if (mode == MODE_FWFT) begin
      rdLoad  = ~memEmpty & (~outValid | rdEn);
      readyRd = outValid;
    end else begin
      rdLoad  = rdEn & ~memEmpty;
      readyRd = ~memEmpty;
    end
  end

  always_ff @(posedge rdClk or negedge rdLive) begin
    if (!rdLive) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rdLoad) begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
    end
  end

  always_ff @(posedge rdClk or negedge rdLive) begin
    if (!rdLive)                  outValid <= 1'b0;
    else if (mode != MODE_FWFT)   outValid <= 1'b0;
    else if (rdLoad)              outValid <= 1'b1;
    else if (rdEn)                outValid <= 1'b0;
  end

  dcFifoPtrSync #(.W(PTR_W)) u_wrToRd (
    .clk   (rdClk),
    .rstN  (rdLive),
    .grayIn(wrGray),
    .binOut(wrSyncBin)
  );

  assign rdOcc       = {1'b0, memCount} + (PTR_W+1)'((mode == MODE_FWFT) & outValid);
  assign almostEmpty = rdOcc <= {1'b0, aeOffset};
  assign rdAddr      = rdBin[ADDR_W-1:0];

  assign strobes.wrPush  = wrPush;
  assign strobes.rdLoad  = rdLoad;
  assign strobes.rdClear = ~rdLive;

  // ------------------------------------------------------------ assertions
  a_r5_no_overflow: assert property (@(posedge wrClk) disable iff (!wrLive)
    wrCount <= DEPTH_P);

  a_r5_full_hold: assert property (@(posedge wrClk) disable iff (!wrLive)
    (wrFull && wrEn) |=> (wrBin == $past(wrBin)));

  a_r5_empty_hold: assert property (@(posedge rdClk) disable iff (!rdLive)
    (memEmpty && rdEn) |=> (rdBin == $past(rdBin)));

  a_r10_wr_gray_step: assert property (@(posedge wrClk) disable iff (!wrLive)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  a_r10_rd_gray_step: assert property (@(posedge rdClk) disable iff (!rdLive)
    $countones(rdGray ^ $past(rdGray)) <= 1);

  a_r8_valid_hold: assert property (@(posedge rdClk) disable iff (!rdLive)
    ((mode == MODE_FWFT) && $fell(outValid)) |-> $past(rdEn));

endmodule

// File: rtl/dcFifoData.sv
`timescale 1ns/1ps
module dcFifoData
  import dcFifoPkg::*;
#(
  parameter  int DEPTH  = 256,
  parameter  int DATA_W = 36,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  fifoStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrPush) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (strobes.rdClear)     rdData <= '0;
    else if (strobes.rdLoad) rdData <= mem[rdAddr];
  end

  a_r2_out_stable: assert property (@(posedge rdClk) disable iff (strobes.rdClear)
    !strobes.rdLoad |=> $stable(rdData));

endmodule

// File: rtl/dcFifo.sv
`timescale 1ns/1ps
module dcFifo
  import dcFifoPkg::*;
#(
  parameter  int DEPTH  = 256,
  parameter  int DATA_W = 36,
  localparam int PTR_W  = $clog2(DEPTH) + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              prstN,
  input  logic              fwftSel,
  input  logic [PTR_W-1:0]  aeOffset,
  input  logic [PTR_W-1:0]  afOffset,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              readyWr,
  output logic              almostFull,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              readyRd,
  output logic              almostEmpty
);

  localparam int ADDR_W = $clog2(DEPTH);

  fifoStrobes_t      strobes;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  dcFifoCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .wrClk      (wrClk),
    .rdClk      (rdClk),
    .rstN       (rstN),
    .prstN      (prstN),
    .fwftSel    (fwftSel),
    .aeOffset   (aeOffset),
    .afOffset   (afOffset),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .strobes    (strobes),
    .readyWr    (readyWr),
    .almostFull (almostFull),
    .readyRd    (readyRd),
    .almostEmpty(almostEmpty)
  );

  dcFifoData #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .wrClk  (wrClk),
    .rdClk  (rdClk),
    .strobes(strobes),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .wrData (wrData),
    .rdData (rdData)
  );

endmodule

// File: tb/test_dcFifo.sv
`timescale 1ns/1ps
module test_dcFifo;

  localparam int DEPTH = 256;
  localparam int DW    = 36;
  localparam int PW    = $clog2(DEPTH) + 1;
  localparam int AE    = 8;
  localparam int AF    = 16;

  logic          wrClk = 1'b0;
  logic          rdClk = 1'b0;
  logic          rstN  = 1'b0;
  logic          prstN = 1'b1;
  logic          fwftSel = 1'b0;
  logic [PW-1:0] aeOffset = PW'(AE);
  logic [PW-1:0] afOffset = PW'(AF);
  logic          wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          rdEn = 1'b0;
  logic          readyWr, almostFull, readyRd, almostEmpty;
  logic [DW-1:0] rdData;

  always #5 wrClk = ~wrClk;   // 100 MHz write clock
  always #7 rdClk = ~rdClk;   // unrelated read clock

  dcFifo #(.DEPTH(DEPTH), .DATA_W(DW)) i_dcFifo (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .prstN(prstN), .fwftSel(fwftSel),
    .aeOffset(aeOffset), .afOffset(afOffset),
    .wrEn(wrEn), .wrData(wrData), .readyWr(readyWr), .almostFull(almostFull),
    .rdEn(rdEn), .rdData(rdData), .readyRd(readyRd), .almostEmpty(almostEmpty)
  );

  int            checks = 0;
  int            errors = 0;
  bit            done = 0;
  bit            fwftNow = 0;
  logic [DW-1:0] model[$];
  int            seq = 1;
  bit            pend = 0;
  logic [DW-1:0] pendVal = '0;
  logic [DW-1:0] lastOut = '0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int s);
    return {4'(s), 32'(s) * 32'h9E3779B1};
  endfunction

  // Write attempts; the model takes a word when readyWr is high before the edge.
  task automatic doWrites(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      if ($urandom_range(99) < pct) begin
        wrEn   = 1'b1;
        wrData = pattern(seq);
        if (readyWr) begin
          model.push_back(wrData);
          seq++;
        end
      end else begin
        wrEn = 1'b0;
      end
    end
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  // Read attempts with a data comparison on every read clock.
  task automatic doReads(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      @(negedge rdClk);
      if (fwftNow) begin
        if (readyRd) begin
          if (model.size() == 0) check("R3 valid with empty model", 64'(readyRd), 64'(0));
          else                   check("R3/R1 fall-through word", 64'(rdData), 64'(model[0]));
        end
      end else begin
        if (pend) check("R1/R2 read word", 64'(rdData), 64'(pendVal));
        else      check("R2 output held", 64'(rdData), 64'(lastOut));
        pend    = 0;
        lastOut = rdData;
      end
      rdEn = ($urandom_range(99) < pct);
      if (rdEn && readyRd) begin
        if (fwftNow) void'(model.pop_front());
        else begin
          pendVal = model.pop_front();
          pend    = 1;
        end
      end
    end
    @(negedge rdClk);
    rdEn = 1'b0;
    if (!fwftNow) begin
      if (pend) check("R1/R2 read word", 64'(rdData), 64'(pendVal));
      pend    = 0;
      lastOut = rdData;
    end
  endtask

  task automatic settle();
    wrEn = 1'b0;
    rdEn = 1'b0;
    repeat (8) @(negedge rdClk);
    repeat (8) @(negedge wrClk);
  endtask

  task automatic checkFlags(input string req);
    int occ;
    int memCnt;
    occ    = model.size();
    memCnt = (fwftNow && occ > 0) ? occ - 1 : occ;
    check({req, " readyRd"},     64'(readyRd),     64'(occ > 0));
    check({req, " readyWr"},     64'(readyWr),     64'(memCnt < DEPTH));
    check({req, " almostEmpty"}, 64'(almostEmpty), 64'(occ <= AE));
    check({req, " almostFull"},  64'(almostFull),  64'((DEPTH - memCnt) <= AF));
  endtask

  task automatic pulseReset(input bit full, input bit sel);
    fwftSel = sel;
    if (full) rstN = 1'b0; else prstN = 1'b0;
    repeat (4) @(negedge rdClk);
    repeat (4) @(negedge wrClk);
    rstN  = 1'b1;
    prstN = 1'b1;
    model.delete();
    pend    = 0;
    lastOut = '0;
    if (full) fwftNow = sel;
    settle();
  endtask

  initial begin
    // ---------------- standard timing
    pulseReset(1, 0);
    checkFlags("R4/R6 reset");
    check("R2 reset output", 64'(rdData), 64'(0));

    doWrites(5, 100);
    settle();
    checkFlags("R4/R6 five words");
    check("R2 no read no output", 64'(rdData), 64'(0));

    fork
      doWrites(400, 60);
      doReads(400, 50);
    join
    doReads(600, 100);          // drains and over-reads
    settle();
    checkFlags("R5 after over-read");

    doWrites(3, 100);
    settle();
    doReads(6, 100);
    settle();
    checkFlags("R5 pointers intact");

    doWrites(DEPTH + 20, 100);  // over-writes once full
    settle();
    checkFlags("R4 full");
    check("R5 accepted count", 64'(model.size()), 64'(DEPTH));
    doReads(DEPTH + 10, 100);
    settle();
    checkFlags("R4 drained");

    doWrites(AE, 100);
    settle();
    checkFlags("R6 at threshold");
    doWrites(1, 100);
    settle();
    checkFlags("R6 above threshold");
    doWrites(DEPTH - AF - 1 - (AE + 1), 100);
    settle();
    checkFlags("R7 below threshold");
    doWrites(1, 100);
    settle();
    checkFlags("R7 at threshold");

    pulseReset(0, 1);           // partial reset, opposite selection ignored
    checkFlags("R9 partial flush");
    doWrites(1, 100);
    settle();
    check("R9 standard kept", 64'(rdData), 64'(0));
    doReads(3, 100);
    settle();

    // ---------------- fall-through timing
    pulseReset(1, 1);
    checkFlags("R9 full reset");
    doWrites(1, 100);
    settle();
    checkFlags("R3 first word");
    check("R3 first word shown", 64'(rdData), 64'(model[0]));

    fork
      doWrites(400, 70);
      doReads(400, 50);
    join
    doReads(600, 100);
    settle();
    checkFlags("R1 fall-through drained");

    doWrites(DEPTH + 20, 100);
    settle();
    checkFlags("R8 full");
    check("R8 capacity", 64'(model.size()), 64'(DEPTH + 1));
    doReads(DEPTH, 100);
    settle();
    checkFlags("R8 last word waiting");
    doReads(1, 100);
    settle();
    checkFlags("R8 last word taken");

    doWrites(AE, 100);
    settle();
    checkFlags("R6 fall-through at threshold");
    doWrites(1, 100);
    settle();
    checkFlags("R6 fall-through above threshold");

    pulseReset(0, 0);
    checkFlags("R9 partial flush fall-through");
    doWrites(1, 100);
    settle();
    checkFlags("R9 fall-through kept");
    doReads(1, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule